// File: doc/BRIEF.md
# Strap-Configured Endian Swap Unit

This block sits in the data path of a bridge that connects a CPU to three kinds of target: the bridge's own internal registers, a PCI-side interface and a memory controller. A target-select input names the destination of the current access. The block reorders the 64-bit data beat and its byte enables on the way out, and the returning read beat on the way back, by a swap policy that belongs to that destination. The memory path is never reordered. The register path follows the endianness captured at reset. The PCI path is controlled by software-visible bits.

While reset is held, the unit samples a strap input that selects a big-endian or little-endian CPU. The captured value fixes the register-path policy for as long as reset stays released. It also seeds two control bits: an endianness bit in a CPU configuration register and a byte-swap bit in a PCI command register. With those defaults, a big-endian CPU sees a little-endian PCI side without any software set-up. Software can later rewrite the two bits through a small write port with byte enables. It can also set a third bit that exchanges the two 32-bit halves of a beat. A separate read port returns register contents one cycle after the address is presented.

Top module: `endian_swap_unit`

## Requirements
- R1: The strap level (1 = big-endian CPU) is captured on every clock while reset is asserted and during the two synchronizer cycles after release. After that the captured value is held, so later strap changes do not alter any data path.
- R2: After reset, the configuration register (address 0x000) reads bit 12 equal to the strap, and the command register (address 0xC00) reads bit 0 equal to the strap and bit 1 as 0. All other bits read 0.
- R3: When target select is 2 or 3 (memory), write data, byte enables and read data pass unchanged, whatever the strap and register settings.
- R4: When target select is 0 (internal registers), the bytes within each 32-bit word are reversed (lane k takes lane k XOR 3) if the captured strap is 1. The beat passes unchanged if the strap is 0. Rewriting the control registers has no effect on this path.
- R5: When target select is 1 (PCI), the byte reversal within each word is applied exactly when command bit 0 and configuration bit 12 are both 1.
- R6: When target select is 1, command bit 1 exchanges the upper and lower 32-bit halves (lane k takes lane k XOR 4). It combines with the byte reversal of R5, giving lane k XOR 7 when both are active.
- R7: Write byte enables (bit k covers data byte k) are permuted by the same lane mapping as the write data on every path.
- R8: A register write updates only implemented bits in lanes whose byte enable is set: bit 12 needs enable bit 1, and bits 0 and 1 need enable bit 0. Writes to any other address, and writes made while reset is active, change nothing.
- R9: Read data appears on the register read port on the clock after the read address is presented. Unknown addresses and unimplemented bits read 0.
- R10: Read data returning from the selected target to the CPU is reordered by the same mapping that the write path uses for that target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_big_i | input | 1 | Endianness strap, 1 = big-endian CPU |
| tgt_sel_i | input | 2 | Destination: 0 registers, 1 PCI, 2/3 memory |
| cpu_wdata_i | input | 64 | Write beat from the CPU |
| cpu_wbe_i | input | 8 | Byte enables of the write beat |
| tgt_wdata_o | output | 64 | Reordered write beat toward the target |
| tgt_wbe_o | output | 8 | Reordered byte enables toward the target |
| tgt_rdata_i | input | 64 | Read beat from the target |
| cpu_rdata_o | output | 64 | Reordered read beat toward the CPU |
| reg_we_i | input | 1 | Control register write strobe |
| reg_waddr_i | input | 12 | Control register write address |
| reg_wdata_i | input | 32 | Control register write data |
| reg_wbe_i | input | 4 | Control register write byte enables |
| reg_raddr_i | input | 12 | Control register read address |
| reg_rdata_o | output | 32 | Control register read data, one cycle after the address |

## Verification
Assertions check the memory-path identity, the byte-enable population count, the identity and byte-reversal forms of the register path, the PCI identity when no PCI swap is enabled, the zero-valued unimplemented read bits and the hold of the captured strap on every cycle. Only the bench scenarios can show the exact lane mapping for every combination of PCI controls. The same applies to the reset defaults for both strap levels, to the masking of register writes by byte enables and address, and to the insensitivity of the register path to strap changes and register rewrites after reset.

// File: rtl/esu_pkg.sv
package esu_pkg;

  typedef enum logic [1:0] {
    TGT_REGS    = 2'd0,
    TGT_PCI     = 2'd1,
    TGT_MEM     = 2'd2,
    TGT_MEM_ALT = 2'd3
  } esu_tgt_e;

  typedef struct packed {
    logic word_sw;
    logic byte_sw;
  } esu_swap_t;

endpackage

// File: rtl/esu_rst_sync.sv
module esu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/esu_ctl_regs.sv
module esu_ctl_regs #(
  parameter int                ADDR_W     = 12,
  parameter int                REG_W      = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 12'h000,
  parameter logic [ADDR_W-1:0] CMD_ADDR   = 12'hC00,
  parameter int                ENDIAN_BIT = 12,
  parameter int                BSW_BIT    = 0,
  parameter int                WSW_BIT    = 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              in_rst,
  input  logic              strap_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W/8-1:0] wbe_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              strap_big_o,
  output logic              cfg_endian_o,
  output logic              cmd_bsw_o,
  output logic              cmd_wsw_o
);

  localparam int BE_W = REG_W / 8;
  localparam logic [REG_W-1:0] CFG_IMPL = REG_W'(1) << ENDIAN_BIT;
  localparam logic [REG_W-1:0] CMD_IMPL = (REG_W'(1) << BSW_BIT) | (REG_W'(1) << WSW_BIT);
  localparam logic [REG_W-1:0] CMD_RST1 = REG_W'(1) << BSW_BIT;

  logic [REG_W-1:0] be_mask;
  logic [REG_W-1:0] cfg_q, cfg_d, cmd_q, cmd_d, rdata_q, rdata_d;
  logic             strap_q, strap_d;
  logic             wr_cfg, wr_cmd;
  logic             strap_en, cfg_en, cmd_en, rd_en;

  genvar b;
  generate
    for (b = 0; b < BE_W; b++) begin : g_bemask
      assign be_mask[b*8 +: 8] = {8{wbe_i[b]}};
    end
  endgenerate

  always_comb begin
    wr_cfg   = we_i && (waddr_i == CFG_ADDR) && !in_rst;
    wr_cmd   = we_i && (waddr_i == CMD_ADDR) && !in_rst;
    strap_en = in_rst;
    cfg_en   = in_rst || wr_cfg;
    cmd_en   = in_rst || wr_cmd;
    rd_en    = 1'b1;

    strap_d = strap_i;

    if (in_rst) begin
      cfg_d = strap_i ? CFG_IMPL : '0;
    end else begin
      cfg_d = (cfg_q & ~(be_mask & CFG_IMPL)) | (wdata_i & be_mask & CFG_IMPL);
    end

    if (in_rst) begin
      cmd_d = strap_i ? CMD_RST1 : '0;
    end else begin
      cmd_d = (cmd_q & ~(be_mask & CMD_IMPL)) | (wdata_i & be_mask & CMD_IMPL);
    end

    if (raddr_i == CFG_ADDR) begin
      rdata_d = cfg_q;
    end else if (raddr_i == CMD_ADDR) begin
      rdata_d = cmd_q;
    end else begin
      rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      strap_q <= 1'b0;
    end else if (strap_en) begin
      strap_q <= strap_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o      = rdata_q;
  assign strap_big_o  = strap_q;
  assign cfg_endian_o = cfg_q[ENDIAN_BIT];
  assign cmd_bsw_o    = cmd_q[BSW_BIT];
  assign cmd_wsw_o    = cmd_q[WSW_BIT];

endmodule

// File: rtl/esu_swap_policy.sv
module esu_swap_policy
  import esu_pkg::*;
(
  input  logic [1:0] tgt_i,
  input  logic       strap_big_i,
  input  logic       cfg_endian_i,
  input  logic       cmd_bsw_i,
  input  logic       cmd_wsw_i,
  output esu_swap_t  swap_o
);

  always_comb begin
    swap_o = '0;
    unique case (esu_tgt_e'(tgt_i))
      TGT_REGS: begin
        swap_o.byte_sw = strap_big_i;
        swap_o.word_sw = 1'b0;
      end
      TGT_PCI: begin
        swap_o.byte_sw = cmd_bsw_i & cfg_endian_i;
        swap_o.word_sw = cmd_wsw_i;
      end
      TGT_MEM, TGT_MEM_ALT: begin
        swap_o = '0;
      end
      default: swap_o = '0;
    endcase
  end

endmodule

// File: rtl/esu_lane_perm.sv
module esu_lane_perm
  import esu_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int WORD_LANES = 4,
  parameter int NUM_WORDS  = 2
) (
  input  logic [LANE_W*WORD_LANES*NUM_WORDS-1:0] vec_i,
  input  esu_swap_t                              sel_i,
  output logic [LANE_W*WORD_LANES*NUM_WORDS-1:0] vec_o
);

  localparam int LANES = WORD_LANES * NUM_WORDS;

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      localparam int WI     = i / WORD_LANES;
      localparam int LI     = i % WORD_LANES;
      localparam int SRC_B  = WI * WORD_LANES + (WORD_LANES - 1 - LI);
      localparam int SRC_W  = (NUM_WORDS - 1 - WI) * WORD_LANES + LI;
      localparam int SRC_BW = (NUM_WORDS - 1 - WI) * WORD_LANES + (WORD_LANES - 1 - LI);

      always_comb begin
        unique case ({sel_i.word_sw, sel_i.byte_sw})
          2'b00:   vec_o[i*LANE_W +: LANE_W] = vec_i[i*LANE_W +: LANE_W];
          2'b01:   vec_o[i*LANE_W +: LANE_W] = vec_i[SRC_B*LANE_W +: LANE_W];
          2'b10:   vec_o[i*LANE_W +: LANE_W] = vec_i[SRC_W*LANE_W +: LANE_W];
          default: vec_o[i*LANE_W +: LANE_W] = vec_i[SRC_BW*LANE_W +: LANE_W];
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/endian_swap_unit.sv
module endian_swap_unit
  import esu_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int WORD_W     = 32,
  parameter int LANE_W     = 8,
  parameter int ADDR_W     = 12,
  parameter int REG_W      = 32,
  parameter int ENDIAN_BIT = 12,
  parameter int BSW_BIT    = 0,
  parameter int WSW_BIT    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strap_big_i,
  input  logic [1:0]               tgt_sel_i,
  input  logic [DATA_W-1:0]        cpu_wdata_i,
  input  logic [DATA_W/LANE_W-1:0] cpu_wbe_i,
  output logic [DATA_W-1:0]        tgt_wdata_o,
  output logic [DATA_W/LANE_W-1:0] tgt_wbe_o,
  input  logic [DATA_W-1:0]        tgt_rdata_i,
  output logic [DATA_W-1:0]        cpu_rdata_o,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_waddr_i,
  input  logic [REG_W-1:0]         reg_wdata_i,
  input  logic [REG_W/8-1:0]       reg_wbe_i,
  input  logic [ADDR_W-1:0]        reg_raddr_i,
  output logic [REG_W-1:0]         reg_rdata_o
);

  localparam int WORD_LANES = WORD_W / LANE_W;
  localparam int NUM_WORDS  = DATA_W / WORD_W;
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'('hC00);

  logic      rst_sync_n;
  logic      in_rst;
  logic      strap_q;
  logic      cfg_endian;
  logic      cmd_bsw;
  logic      cmd_wsw;
  esu_swap_t path_swap;

  esu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign in_rst = !rst_sync_n;

  esu_ctl_regs #(
    .ADDR_W     (ADDR_W),
    .REG_W      (REG_W),
    .CFG_ADDR   (CFG_ADDR),
    .CMD_ADDR   (CMD_ADDR),
    .ENDIAN_BIT (ENDIAN_BIT),
    .BSW_BIT    (BSW_BIT),
    .WSW_BIT    (WSW_BIT)
  ) u_regs (
    .clk          (clk),
    .arst_n       (rst_n),
    .in_rst       (in_rst),
    .strap_i      (strap_big_i),
    .we_i         (reg_we_i),
    .waddr_i      (reg_waddr_i),
    .wdata_i      (reg_wdata_i),
    .wbe_i        (reg_wbe_i),
    .raddr_i      (reg_raddr_i),
    .rdata_o      (reg_rdata_o),
    .strap_big_o  (strap_q),
    .cfg_endian_o (cfg_endian),
    .cmd_bsw_o    (cmd_bsw),
    .cmd_wsw_o    (cmd_wsw)
  );

  esu_swap_policy u_policy (
    .tgt_i        (tgt_sel_i),
    .strap_big_i  (strap_q),
    .cfg_endian_i (cfg_endian),
    .cmd_bsw_i    (cmd_bsw),
    .cmd_wsw_i    (cmd_wsw),
    .swap_o       (path_swap)
  );

  esu_lane_perm #(.LANE_W(LANE_W), .WORD_LANES(WORD_LANES), .NUM_WORDS(NUM_WORDS)) u_wdata_perm (
    .vec_i (cpu_wdata_i),
    .sel_i (path_swap),
    .vec_o (tgt_wdata_o)
  );

  esu_lane_perm #(.LANE_W(1), .WORD_LANES(WORD_LANES), .NUM_WORDS(NUM_WORDS)) u_wbe_perm (
    .vec_i (cpu_wbe_i),
    .sel_i (path_swap),
    .vec_o (tgt_wbe_o)
  );

  esu_lane_perm #(.LANE_W(LANE_W), .WORD_LANES(WORD_LANES), .NUM_WORDS(NUM_WORDS)) u_rdata_perm (
    .vec_i (tgt_rdata_i),
    .sel_i (path_swap),
    .vec_o (cpu_rdata_o)
  );

endmodule

// File: rtl/esu_checker.sv
module esu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_rst,
  input logic        strap_q,
  input logic        cfg_endian,
  input logic        cmd_bsw,
  input logic        cmd_wsw,
  input logic [1:0]  tgt_sel_i,
  input logic [63:0] cpu_wdata_i,
  input logic [7:0]  cpu_wbe_i,
  input logic [63:0] tgt_wdata_o,
  input logic [7:0]  tgt_wbe_o,
  input logic [63:0] tgt_rdata_i,
  input logic [63:0] cpu_rdata_o,
  input logic [31:0] reg_rdata_o
);

  localparam logic [31:0] READ_IMPL = 32'h0000_1003;

  assert_mem_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel_i[1] |-> (tgt_wdata_o == cpu_wdata_i) && (tgt_wbe_o == cpu_wbe_i)
                     && (cpu_rdata_o == tgt_rdata_i));

  assert_be_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tgt_wbe_o) == $countones(cpu_wbe_i));

  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rst && !$past(in_rst)) |-> $stable(strap_q));

  assert_regs_le_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel_i == 2'd0 && !strap_q) |-> (tgt_wdata_o == cpu_wdata_i));

  assert_regs_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel_i == 2'd0 && strap_q) |->
      (tgt_wdata_o[7:0] == cpu_wdata_i[31:24]) && (tgt_wdata_o[63:56] == cpu_wdata_i[39:32]));

  assert_pci_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel_i == 2'd1 && !cmd_wsw && !(cmd_bsw && cfg_endian)) |->
      (tgt_wdata_o == cpu_wdata_i) && (cpu_rdata_o == tgt_rdata_i));

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & ~READ_IMPL) == 32'd0);

endmodule

bind endian_swap_unit esu_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_rst      (in_rst),
  .strap_q     (strap_q),
  .cfg_endian  (cfg_endian),
  .cmd_bsw     (cmd_bsw),
  .cmd_wsw     (cmd_wsw),
  .tgt_sel_i   (tgt_sel_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_wbe_i   (cpu_wbe_i),
  .tgt_wdata_o (tgt_wdata_o),
  .tgt_wbe_o   (tgt_wbe_o),
  .tgt_rdata_i (tgt_rdata_i),
  .cpu_rdata_o (cpu_rdata_o),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/endian_swap_unit_bench.sv
`timescale 1ns/1ps
module endian_swap_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        strap;
  logic [1:0]  tgt_sel;
  logic [63:0] cpu_wdata, tgt_wdata, tgt_rdata, cpu_rdata;
  logic [7:0]  cpu_wbe, tgt_wbe;
  logic        reg_we;
  logic [11:0] reg_waddr, reg_raddr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0]  reg_wbe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the control bits
  bit m_strap, m_endian, m_bsw, m_wsw;

  endian_swap_unit u_endian_swap_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_big_i (strap),
    .tgt_sel_i   (tgt_sel),
    .cpu_wdata_i (cpu_wdata),
    .cpu_wbe_i   (cpu_wbe),
    .tgt_wdata_o (tgt_wdata),
    .tgt_wbe_o   (tgt_wbe),
    .tgt_rdata_i (tgt_rdata),
    .cpu_rdata_o (cpu_rdata),
    .reg_we_i    (reg_we),
    .reg_waddr_i (reg_waddr),
    .reg_wdata_i (reg_wdata),
    .reg_wbe_i   (reg_wbe),
    .reg_raddr_i (reg_raddr),
    .reg_rdata_o (reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] perm64(logic [63:0] d, bit bs, bit ws);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      int src;
      src = k ^ (bs ? 3 : 0) ^ (ws ? 4 : 0);
      r[k*8 +: 8] = d[src*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [7:0] perm8(logic [7:0] e, bit bs, bit ws);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      int src;
      src = k ^ (bs ? 3 : 0) ^ (ws ? 4 : 0);
      r[k] = e[src];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected swap for a target, from the requirements
  task automatic exp_swap(logic [1:0] sel, output bit bs, output bit ws);
    bs = 0; ws = 0;
    if (sel == 2'd0) bs = m_strap;                       // R4
    else if (sel == 2'd1) begin bs = m_bsw & m_endian; ws = m_wsw; end // R5 R6
  endtask

  task automatic data_check(logic [1:0] sel, logic [63:0] wd, logic [7:0] be,
                            logic [63:0] rd, string req);
    bit bs, ws;
    @(negedge clk);
    tgt_sel = sel; cpu_wdata = wd; cpu_wbe = be; tgt_rdata = rd;
    #2;
    exp_swap(sel, bs, ws);
    chk(req, tgt_wdata, perm64(wd, bs, ws));
    chk({req, " R7"}, {56'd0, tgt_wbe}, {56'd0, perm8(be, bs, ws)});
    chk({req, " R10"}, cpu_rdata, perm64(rd, bs, ws));
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_we = 1; reg_waddr = a; reg_wdata = d; reg_wbe = be;
    @(negedge clk);
    reg_we = 0;
    if (a == 12'h000 && be[1]) m_endian = d[12];
    if (a == 12'hC00 && be[0]) begin m_bsw = d[0]; m_wsw = d[1]; end
  endtask

  task automatic reg_read_check(logic [11:0] a, string req);
    logic [31:0] exp;
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    exp = 32'd0;
    if (a == 12'h000) exp[12] = m_endian;
    if (a == 12'hC00) begin exp[0] = m_bsw; exp[1] = m_wsw; end
    chk(req, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic do_reset(bit s);
    rst_n = 0; strap = s; reg_we = 0;
    repeat (4) @(negedge clk);
    // R8: a write while reset is held must not stick
    reg_we = 1; reg_waddr = 12'hC00; reg_wdata = 32'h3; reg_wbe = 4'hF;
    @(negedge clk);
    reg_we = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_strap = s; m_endian = s; m_bsw = s; m_wsw = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tgt_sel = 0; cpu_wdata = 0; cpu_wbe = 0; tgt_rdata = 0;
    reg_we = 0; reg_waddr = 0; reg_wdata = 0; reg_wbe = 0; reg_raddr = 0;
    strap = 0; rst_n = 0;

    for (int pass = 0; pass < 2; pass++) begin
      bit s;
      s = (pass == 1);
      do_reset(s);
      // R2 reset state (also R8: write during reset ignored)
      reg_read_check(12'h000, "R2 cfg reset");
      reg_read_check(12'hC00, "R2 cmd reset");
      reg_read_check(12'h400, "R9 unknown addr");
      // R1: strap flips after reset, register path keeps old policy
      @(negedge clk); strap = ~s;
      data_check(2'd0, 64'h0011223344556677, 8'b0000_0110, 64'h8899AABBCCDDEEFF, "R1 strap held");
      // directed corner cases
      data_check(2'd2, 64'h0102030405060708, 8'h0F, 64'hF0E0D0C0B0A09080, "R3 mem");
      data_check(2'd3, 64'hDEADBEEFCAFEF00D, 8'h81, 64'h1234567890ABCDEF, "R3 mem alt");
      data_check(2'd1, 64'h0102030405060708, 8'h01, 64'h1112131415161718, "R5 pci default");
      // R4 register path ignores control rewrites
      reg_write(12'h000, ~{31'd0, s} << 12, 4'h2);
      reg_write(12'hC00, 32'h3, 4'h1);
      data_check(2'd0, 64'hA1A2A3A4B1B2B3B4, 8'h13, 64'hC1C2C3C4D1D2D3D4, "R4 regs after rewrite");
      // R6 combined swaps on PCI
      reg_write(12'h000, 32'h1000, 4'h2);
      data_check(2'd1, 64'h0706050403020100, 8'h01, 64'h0F0E0D0C0B0A0908, "R6 pci both");
      reg_write(12'hC00, 32'h2, 4'h1);
      data_check(2'd1, 64'h0706050403020100, 8'h30, 64'h0F0E0D0C0B0A0908, "R6 pci word only");
      // R8 byte enable masking and foreign address
      reg_write(12'hC00, 32'h1, 4'hE);
      reg_read_check(12'hC00, "R8 be masked cmd");
      reg_write(12'h000, 32'h0, 4'hD);
      reg_read_check(12'h000, "R8 be masked cfg");
      reg_write(12'h004, 32'hFFFF_FFFF, 4'hF);
      reg_read_check(12'h000, "R8 other addr cfg");
      reg_read_check(12'hC00, "R8 other addr cmd");
      // R9 latency: read address changes, data follows one clock later
      @(negedge clk); reg_raddr = 12'h000;
      @(negedge clk); reg_raddr = 12'hC00;
      chk("R9 latency", {32'd0, reg_rdata}, {51'd0, m_endian, 12'd0});

      // constrained random traffic
      for (int it = 0; it < 300; it++) begin
        int kind;
        kind = $urandom_range(0, 9);
        if (kind == 0) begin
          logic [11:0] a;
          int pick;
          pick = $urandom_range(0, 2);
          a = (pick == 0) ? 12'h000 : (pick == 1) ? 12'hC00 : 12'($urandom_range(1, 4095));
          if (a == 12'hC00 && pick == 2) a = 12'h800;
          reg_write(a, $urandom(), 4'($urandom_range(0, 15)));
        end else if (kind == 1) begin
          reg_read_check($urandom_range(0, 1) ? 12'h000 : 12'hC00, "R9 random read");
        end else begin
          data_check(2'($urandom_range(0, 3)), {$urandom(), $urandom()},
                     8'($urandom_range(0, 255)), {$urandom(), $urandom()}, "R5 random path");
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule